// File: doc/BRIEF.md
# MSI Doorbell Interrupt Aggregator

This block gathers message-signalled interrupts and merges them onto a single level-sensitive interrupt line for a host interrupt controller. A sender raises vector n by writing the value n into a doorbell word that belongs to that vector alone. The vector port places these words at byte offset 4*n. Each accepted doorbell write sets a pending flag and stores the written word. The interrupt line is the registered OR of every pending flag whose enable bit is set.

Software works through a small control port that holds three registers: a read-only pending view, a sticky error register and an enable mask. The service routine reads the pending view and handles the set bits from the lowest to the highest. It reads each serviced vector's doorbell word, which returns the stored message and clears that flag. It then reads the pending view again until the view is zero. A doorbell write that names a vector outside the configured count, or that carries the wrong value, is dropped and recorded in the error register.

The number of live vectors is a parameter of at most 32. Both ports are simple single-cycle slaves. Their read data is combinational from the address, and their writes take effect at the clock edge.

Top module: `msi_agg`

## Requirements
- R1: The control port decodes the pending view at byte offset 0x0, the error register at 0x4 and the enable mask at 0x8. Any other control offset reads zero. Mask bits at or above NUM_VEC read as zero.
- R2: A write to the word-aligned vector-port offset 4*n, with data equal to n and n below NUM_VEC, sets pending bit n (bit n of offset 0x0) at the next clock edge.
- R3: A read of vector word n returns the word stored by its last accepted write and clears pending bit n at that clock edge. A read of a word at or above NUM_VEC returns zero.
- R4: A pending bit stays set until its own doorbell word is read. Reads of the pending view and reads of other vectors' words do not clear it.
- R5: When a write and a read hit the same doorbell word in one cycle, the write wins and the pending bit stays set.
- R6: A doorbell write to word index n is dropped, and sets error bit n, if n is at or above NUM_VEC or if the data is not n. The pending bits are left unchanged.
- R7: Writing 1 to a bit of the error register at 0x4 clears that bit. Bits written with 0 keep their value.
- R8: Mask bit n set to 1 enables vector n. The irq output equals the OR over all n of (pending n AND mask n), taken one clock after that state. A zero mask holds irq low.
- R9: Writes to the pending view at offset 0x0 have no effect on the pending bits.
- R10: A synchronous active-low reset clears all pending bits, error bits, mask bits and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Control-port write strobe |
| csr_addr | input | 4 | Control-port byte address |
| csr_wdata | input | 32 | Control-port write data |
| csr_rdata | output | 32 | Control-port read data, combinational from csr_addr |
| vec_wr | input | 1 | Doorbell write strobe |
| vec_rd | input | 1 | Doorbell read strobe (clears the addressed pending bit) |
| vec_addr | input | 7 | Doorbell byte address; only word-aligned addresses decode |
| vec_wdata | input | 32 | Doorbell write data (must equal the vector number) |
| vec_rdata | output | 32 | Doorbell read data, combinational from vec_addr |
| irq | output | 1 | Registered level interrupt to the host controller |

## Verification
The assertions check on every cycle that an accepted doorbell sets its flag and a read clears it, and that a dropped write raises its error bit without touching the pending state. They also check that pending state holds when no doorbell access occurs and that irq tracks the masked pending state one cycle later. Only the bench scenarios can show the read data returned per vector, the register decode and masking of unused bits, the write-one-to-clear error behaviour, and the write-wins outcome of a simultaneous write and read. The same holds for the exact cycles at which irq rises and falls, and for clearing by reset in the middle of a run.

// File: rtl/msi_agg_pkg.sv
// Shared constants and the control-register decode for the MSI doorbell
// aggregator. Assumes a 32-bit data bus and at most 32 vectors.
package msi_agg_pkg;

    localparam int BUS_W   = 32;
    localparam int MAX_VEC = 32;
    localparam int CSR_AW  = 4;
    localparam int VEC_AW  = $clog2(MAX_VEC * 4);

    localparam logic [CSR_AW-1:0] OFS_PEND = 4'h0;
    localparam logic [CSR_AW-1:0] OFS_ERR  = 4'h4;
    localparam logic [CSR_AW-1:0] OFS_MASK = 4'h8;

    typedef enum logic [1:0] {
        SEL_PEND,
        SEL_ERR,
        SEL_MASK,
        SEL_NONE
    } csr_sel_e;

    // Map a control byte address onto the register it selects.
    function automatic csr_sel_e csr_decode(input logic [CSR_AW-1:0] a);
        csr_sel_e s;
        case (a)
            OFS_PEND: s = SEL_PEND;
            OFS_ERR:  s = SEL_ERR;
            OFS_MASK: s = SEL_MASK;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/msi_agg_vec_bank.sv
// Doorbell bank: one pending flag and one stored message word per live vector.
// Decodes the vector port and reports malformed writes as one-hot error events.
// Assumes at most one access address per cycle; a read and a write strobe
// asserted together refer to the same word. Unaligned addresses are ignored.
module msi_agg_vec_bank
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vec_wr,
    input  logic               vec_rd,
    input  logic [VEC_AW-1:0]  vec_addr,
    input  logic [BUS_W-1:0]   vec_wdata,
    output logic [BUS_W-1:0]   vec_rdata,
    output logic [MAX_VEC-1:0] pend,
    output logic [MAX_VEC-1:0] err_evt
);

    localparam int IDX_W = VEC_AW - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             in_range;
    logic [BUS_W-1:0] slot_data [MAX_VEC];

    // Split the byte address into a word index and an alignment flag.
    assign idx      = vec_addr[VEC_AW-1:2];
    assign aligned  = (vec_addr[1:0] == 2'b00);
    assign in_range = (int'(idx) < NUM_VEC);

    generate
        for (genvar n = 0; n < MAX_VEC; n++) begin : g_slot
            if (n < NUM_VEC) begin : g_live
                logic             hit;
                logic             wr_ok;
                logic             rd_clr;
                logic             pend_q;
                logic [BUS_W-1:0] data_q;

                assign hit    = aligned && (idx == IDX_W'(n));
                assign wr_ok  = hit && vec_wr && (vec_wdata == BUS_W'(n));
                assign rd_clr = hit && vec_rd;

                // Pending flag: an accepted write sets it, a read clears it; the write wins.
                always_ff @(posedge clk) begin
                    if (!rst_n)      pend_q <= 1'b0;
                    else if (wr_ok)  pend_q <= 1'b1;
                    else if (rd_clr) pend_q <= 1'b0;
                end

                // Message store: keeps the word of the last accepted write.
                always_ff @(posedge clk) begin
                    if (!rst_n)     data_q <= '0;
                    else if (wr_ok) data_q <= vec_wdata;
                end

                assign pend[n]      = pend_q;
                assign slot_data[n] = data_q;
            end else begin : g_absent
                assign pend[n]      = 1'b0;
                assign slot_data[n] = '0;
            end
        end
    endgenerate

    // Read path: the stored word of a live vector, zero elsewhere.
    assign vec_rdata = (aligned && in_range) ? slot_data[idx] : '0;

    // Error events: an out-of-range index or a mismatched value flags bit idx.
    always_comb begin
        err_evt = '0;
        if (vec_wr && aligned && (!in_range || (vec_wdata != BUS_W'(idx)))) begin
            err_evt[idx] = 1'b1;
        end
    end

endmodule

// File: rtl/msi_agg_csr.sv
// Control registers: a read-only pending view, a sticky error register
// (write 1 to clear) and the enable mask. Read data is combinational.
// Assumes err_evt and pend come from the doorbell bank in the same cycle.
module msi_agg_csr
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_wr,
    input  logic [CSR_AW-1:0]  csr_addr,
    input  logic [BUS_W-1:0]   csr_wdata,
    input  logic [MAX_VEC-1:0] pend,
    input  logic [MAX_VEC-1:0] err_evt,
    output logic [BUS_W-1:0]   csr_rdata,
    output logic [MAX_VEC-1:0] mask_q,
    output logic [MAX_VEC-1:0] err_q
);

    localparam logic [MAX_VEC-1:0] LIVE = MAX_VEC'((64'd1 << NUM_VEC) - 64'd1);

    csr_sel_e   sel;
    logic [MAX_VEC-1:0] err_clr;

    assign sel     = csr_decode(csr_addr);
    assign err_clr = (csr_wr && sel == SEL_ERR) ? csr_wdata[MAX_VEC-1:0] : '0;

    // Enable mask: software write, bits of absent vectors forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask_q <= '0;
        else if (csr_wr && sel == SEL_MASK) mask_q <= csr_wdata[MAX_VEC-1:0] & LIVE;
    end

    // Error register: new events set bits, written ones clear them; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~err_clr) | err_evt;
    end

    // Read multiplexer: undecoded offsets return zero.
    always_comb begin
        csr_rdata = '0;
        case (sel)
            SEL_PEND: csr_rdata = BUS_W'(pend);
            SEL_ERR:  csr_rdata = BUS_W'(err_q);
            SEL_MASK: csr_rdata = BUS_W'(mask_q);
            default:  csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/msi_agg_irq.sv
// Interrupt merge: registers the OR of all enabled pending flags onto one line.
// Assumes pend and mask are already synchronous to clk.
module msi_agg_irq
    import msi_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MAX_VEC-1:0] pend,
    input  logic [MAX_VEC-1:0] mask,
    output logic               irq
);

    // Level output: one flop after the masked reduction.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(pend & mask);
    end

endmodule

// File: rtl/msi_agg.sv
// Top of the MSI doorbell aggregator: doorbell bank, control registers and
// the interrupt merge. Assumes single-cycle slave ports with no wait states.
module msi_agg
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [BUS_W-1:0]  csr_wdata,
    output logic [BUS_W-1:0]  csr_rdata,
    input  logic              vec_wr,
    input  logic              vec_rd,
    input  logic [VEC_AW-1:0] vec_addr,
    input  logic [BUS_W-1:0]  vec_wdata,
    output logic [BUS_W-1:0]  vec_rdata,
    output logic              irq
);

    logic [MAX_VEC-1:0] pend_w;
    logic [MAX_VEC-1:0] evt_w;
    logic [MAX_VEC-1:0] mask_w;
    logic [MAX_VEC-1:0] err_w;

    msi_agg_vec_bank #(.NUM_VEC(NUM_VEC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .vec_wr    (vec_wr),
        .vec_rd    (vec_rd),
        .vec_addr  (vec_addr),
        .vec_wdata (vec_wdata),
        .vec_rdata (vec_rdata),
        .pend      (pend_w),
        .err_evt   (evt_w)
    );

    msi_agg_csr #(.NUM_VEC(NUM_VEC)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .pend      (pend_w),
        .err_evt   (evt_w),
        .csr_rdata (csr_rdata),
        .mask_q    (mask_w),
        .err_q     (err_w)
    );

    msi_agg_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend_w),
        .mask  (mask_w),
        .irq   (irq)
    );

endmodule

// File: rtl/msi_agg_chk.sv
// Assertion checker for msi_agg, attached by bind. Decodes the vector port
// on its own and relates accesses to the pending, error, mask and irq state.
module msi_agg_chk
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vec_wr,
    input logic               vec_rd,
    input logic [VEC_AW-1:0]  vec_addr,
    input logic [BUS_W-1:0]   vec_wdata,
    input logic [MAX_VEC-1:0] pend,
    input logic [MAX_VEC-1:0] mask,
    input logic [MAX_VEC-1:0] err,
    input logic               irq
);

    logic [4:0] w_idx;
    logic       w_al;
    logic       good_wr;
    logic       bad_wr;

    assign w_idx   = vec_addr[VEC_AW-1:2];
    assign w_al    = (vec_addr[1:0] == 2'b00);
    assign good_wr = vec_wr && w_al && (int'(w_idx) < NUM_VEC) && (vec_wdata == 32'(w_idx));
    assign bad_wr  = vec_wr && w_al && !((int'(w_idx) < NUM_VEC) && (vec_wdata == 32'(w_idx)));

    // R2
    doorbell_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good_wr |=> pend[$past(w_idx)]);

    // R3
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !vec_wr && w_al) |=> !pend[$past(w_idx)]);

    // R6
    bad_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> err[$past(w_idx)]);

    // R6
    bad_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_wr && !vec_rd) |=> (pend == $past(pend)));

    // R4 R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_wr && !vec_rd) |=> (pend == $past(pend)));

    // R8
    irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(pend & mask)));

    // R8
    zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !irq);

endmodule

bind msi_agg msi_agg_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_wr    (vec_wr),
    .vec_rd    (vec_rd),
    .vec_addr  (vec_addr),
    .vec_wdata (vec_wdata),
    .pend      (pend_w),
    .mask      (mask_w),
    .err       (err_w),
    .irq       (irq)
);

// File: tb/tb_msi_agg.sv
// Self-checking bench: a step table walked by one loop, then directed
// tests for reset, interrupt latency and the simultaneous write/read case.
module tb_msi_agg;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 8;

    typedef enum logic [2:0] {OP_CWR, OP_CRD, OP_VWR, OP_VRD, OP_IRQ} op_e;
    typedef struct packed {
        op_e         op;
        logic [7:0]  addr;
        logic [31:0] data;   // write data, or expected read value
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 23;
    localparam step_t STEPS [NSTEP] = '{
        '{OP_CWR, 8'h08, 32'hFFFF_FFFF, 8'd1},  // R1 mask write, upper bits dropped
        '{OP_CRD, 8'h08, 32'h0000_00FF, 8'd1},  // R1 mask readback
        '{OP_VWR, 8'h0C, 32'd3,         8'd2},  // R2 doorbell 3
        '{OP_CRD, 8'h00, 32'h0000_0008, 8'd2},  // R2 pending 3
        '{OP_VWR, 8'h14, 32'd5,         8'd2},  // R2 doorbell 5
        '{OP_CRD, 8'h00, 32'h0000_0028, 8'd2},  // R2 pending 3 and 5
        '{OP_IRQ, 8'h00, 32'd1,         8'd8},  // R8 irq raised
        '{OP_VRD, 8'h0C, 32'd3,         8'd3},  // R3 read returns message
        '{OP_CRD, 8'h00, 32'h0000_0020, 8'd4},  // R4 only 3 cleared
        '{OP_VWR, 8'h08, 32'd7,         8'd6},  // R6 wrong data for vector 2
        '{OP_CRD, 8'h04, 32'h0000_0004, 8'd6},  // R6 error bit 2
        '{OP_CRD, 8'h00, 32'h0000_0020, 8'd6},  // R6 pending untouched
        '{OP_VWR, 8'h28, 32'd10,        8'd6},  // R6 vector 10 out of range
        '{OP_CRD, 8'h04, 32'h0000_0404, 8'd6},  // R6 error bit 10
        '{OP_CWR, 8'h04, 32'h0000_0004, 8'd7},  // R7 clear bit 2
        '{OP_CRD, 8'h04, 32'h0000_0400, 8'd7},  // R7 bit 10 kept
        '{OP_CWR, 8'h00, 32'hFFFF_FFFF, 8'd9},  // R9 write to pending view
        '{OP_CRD, 8'h00, 32'h0000_0020, 8'd9},  // R9 pending unchanged
        '{OP_CRD, 8'h0C, 32'h0000_0000, 8'd1},  // R1 undecoded offset
        '{OP_CWR, 8'h08, 32'h0000_0000, 8'd8},  // R8 mask off
        '{OP_IRQ, 8'h00, 32'd0,         8'd8},  // R8 irq low with zero mask
        '{OP_VRD, 8'h14, 32'd5,         8'd3},  // R3 read vector 5
        '{OP_VRD, 8'h28, 32'd0,         8'd3}   // R3 out-of-range read is zero
    };

    logic        clk;
    logic        rst_n;
    logic        csr_wr;
    logic [3:0]  csr_addr;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic        vec_wr;
    logic        vec_rd;
    logic [6:0]  vec_addr;
    logic [31:0] vec_wdata;
    logic [31:0] vec_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    msi_agg #(.NUM_VEC(NV)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .vec_wr    (vec_wr),
        .vec_rd    (vec_rd),
        .vec_addr  (vec_addr),
        .vec_wdata (vec_wdata),
        .vec_rdata (vec_rdata),
        .irq       (irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a[3:0]; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a[3:0];
        #1 d = csr_rdata;
    endtask

    task automatic vec_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        vec_wr = 1'b1; vec_addr = a[6:0]; vec_wdata = d;
        @(negedge clk);
        vec_wr = 1'b0;
    endtask

    task automatic vec_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        vec_rd = 1'b1; vec_addr = a[6:0];
        #1 d = vec_rdata;
        @(negedge clk);
        vec_rd = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; csr_wr = 1'b0; csr_addr = '0; csr_wdata = '0;
        vec_wr = 1'b0; vec_rd = 1'b0; vec_addr = '0; vec_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        csr_read(8'h00, rd); check("R10 pending after reset", rd, 32'h0);
        csr_read(8'h04, rd); check("R10 error after reset", rd, 32'h0);
        csr_read(8'h08, rd); check("R10 mask after reset", rd, 32'h0);
        check("R10 irq after reset", {31'b0, irq}, 32'h0);

        // Table walk
        for (int i = 0; i < NSTEP; i++) begin
            string tag;
            tag = $sformatf("R%0d step %0d", STEPS[i].req, i);
            case (STEPS[i].op)
                OP_CWR: csr_write(STEPS[i].addr, STEPS[i].data);
                OP_VWR: vec_write(STEPS[i].addr, STEPS[i].data);
                OP_CRD: begin csr_read(STEPS[i].addr, rd); check(tag, rd, STEPS[i].data); end
                OP_VRD: begin vec_read(STEPS[i].addr, rd); check(tag, rd, STEPS[i].data); end
                default: begin
                    @(negedge clk);
                    check(tag, {31'b0, irq}, STEPS[i].data);
                end
            endcase
        end

        // R8 rise and fall latency: one clock behind the pending state
        csr_write(8'h08, 32'h2);
        vec_write(8'h04, 32'd1);
        check("R8 irq not yet high", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R8 irq high one clock later", {31'b0, irq}, 32'h1);
        vec_read(8'h04, rd);
        check("R3 message of vector 1", rd, 32'd1);
        check("R8 irq still high at clear edge", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R8 irq low one clock after clear", {31'b0, irq}, 32'h0);

        // R5 write and read of the same word in one cycle
        @(negedge clk);
        vec_wr = 1'b1; vec_rd = 1'b1; vec_addr = 7'h08; vec_wdata = 32'd2;
        @(negedge clk);
        vec_wr = 1'b0; vec_rd = 1'b0;
        csr_read(8'h00, rd); check("R5 write wins over read", rd, 32'h4);
        vec_read(8'h08, rd); check("R5 stored word", rd, 32'd2);
        csr_read(8'h00, rd); check("R3 cleared after read", rd, 32'h0);

        // R10 reset in the middle of activity
        csr_write(8'h08, 32'hFF);
        vec_write(8'h00, 32'd0);
        vec_write(8'h10, 32'd9);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        csr_read(8'h00, rd); check("R10 pending cleared", rd, 32'h0);
        csr_read(8'h04, rd); check("R10 error cleared", rd, 32'h0);
        csr_read(8'h08, rd); check("R10 mask cleared", rd, 32'h0);
        check("R10 irq cleared", {31'b0, irq}, 32'h0);

        finish_run();
    end

endmodule